// File: doc/BRIEF.md
# Two-Phase Handshake Latch Pipeline with Join and Fork

This block is a linear chain of self-timed pipeline stages. Each stage keeps a data latch that stays open while the stage is empty and closes once an item has been captured. A single XNOR of the stage's own completion bit and the completion bit of the stage after it forms the latch enable. Handshakes are two-phase: a request wire toggles once per item, in either direction, and the matching acknowledge toggles once when that item has been taken. Nothing ever returns to zero. The design is written as a discrete-time model. `clk` is the sampling grid on which the latches and C-elements are evaluated. It is not a pipeline clock: an item moves forward only when its request toggles and the enable is open.

Two producers, A and B, feed the head through a join. A C-element merges their requests, and the head sees the sum of both data words. Both producers receive the same acknowledge. The tail feeds two consumers, X and Y, through a fork. Both consumers see the same request and data, and a C-element merges their acknowledges. Each stage can optionally add one to the word it passes on. The request entering each stage goes through a delay line whose length matches the stage logic, so the request always arrives after the data has settled.

Flow control is the two-phase handshake itself, not valid/ready. A producer may toggle its request only when the request equals its acknowledge. It must then hold its data until the acknowledge catches up. A consumer takes an item when request differs from acknowledge, and it releases the item by toggling the acknowledge. Back-pressure comes from a consumer that delays its toggle.

Top module: `tsp_pipe`

## Requirements
- R1: While `rst_n` is low, and after its release until a producer toggles, `a_ack`, `b_ack`, `x_req` and `y_req` are all 0.
- R2: Every item is delivered exactly once and in order. An item is one toggle of `a_req` and one of `b_req`, each of which may be a rise or a fall. It leaves on `x_data` and `y_data` as (a_data + b_data + NUM_STAGES) mod 2^W when the stage operation is increment.
- R3: The join acts only when both producers have toggled. A toggle of `a_req` alone leaves `a_ack`, `b_ack` and `x_req` unchanged. `a_ack` and `b_ack` toggle only once both requests differ from the acknowledge.
- R4: The fork offers the next item only after both consumers have acknowledged. While `y_ack` lags, `x_req` does not toggle again, even if `x_ack` has been toggled and items are queued.
- R5: With both consumers stalled, exactly NUM_STAGES items are accepted (NUM_STAGES toggles of `a_ack`). After that the acknowledges stay still.
- R6: In an empty pipeline, `x_req` toggles 1 + NUM_STAGES*(MATCH_DLY+1) sampling edges after the first edge at which both producer requests differ from the acknowledge.
- R7: A stage captures a new item only when it is empty, meaning its completion bit equals the next stage's. While it is full, its held data does not change. During a long stall, `x_data` stays at the oldest undelivered item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling grid for the discrete-time model |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Producer A request; each toggle is one item |
| a_data | input | W | Producer A data, held until `a_ack` follows |
| a_ack | output | 1 | Acknowledge to producer A |
| b_req | input | 1 | Producer B request; each toggle is one item |
| b_data | input | W | Producer B data, held until `b_ack` follows |
| b_ack | output | 1 | Acknowledge to producer B |
| x_req | output | 1 | Request to consumer X |
| x_data | output | W | Item data to consumer X |
| x_ack | input | 1 | Acknowledge from consumer X |
| y_req | output | 1 | Request to consumer Y |
| y_data | output | W | Item data to consumer Y |
| y_ack | input | 1 | Acknowledge from consumer Y |

## Verification
The bench toggles one producer alone and then the other. A join that let either request through would acknowledge early, and the sum it passed on would lose one operand. It stalls both consumers to fill every stage. An enable with the wrong polarity, or with no hold, would either accept a fifth item or overwrite a held one, and the scoreboard would then report loss, duplication or reordering. It also holds back only consumer Y to show that a fork which releases on one acknowledge offers a second item too early. The empty-pipe latency is measured exactly, which exposes a delay line of the wrong length.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic {
    OP_PASS = 1'b0,
    OP_INC  = 1'b1
  } stage_op_e;
endpackage

// File: rtl/tsp_celem.sv
module tsp_celem #(
  parameter int N_IN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] ins,
  output logic            c_out
);
  logic c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     c_q <= 1'b0;
    else if (ins == {N_IN{1'b1}})   c_q <= 1'b1;
    else if (ins == {N_IN{1'b0}})   c_q <= 1'b0;
  end

  assign c_out = c_q;

  // R3
  celem_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q != $past(c_q)) |-> ($past(ins) == {N_IN{c_q}}));
endmodule

// File: rtl/tsp_delay.sv
module tsp_delay #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic taps [DLY+1];
  assign taps[0] = d;

  for (genvar g = 0; g < DLY; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[g+1] <= 1'b0;
      else        taps[g+1] <= taps[g];
    end
  end

  assign q = taps[DLY];
endmodule

// File: rtl/tsp_stage.sv
module tsp_stage #(
  parameter int                  W   = 8,
  parameter int                  DLY = 1,
  parameter tsp_pkg::stage_op_e  OP  = tsp_pkg::OP_INC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_in,
  input  logic [W-1:0] data_in,
  input  logic         done_next,
  output logic         done,
  output logic [W-1:0] data_out
);
  logic         req_late;
  logic         en;
  logic         done_q;
  logic [W-1:0] data_q;
  logic [W-1:0] logic_out;

  tsp_delay #(.DLY(DLY)) u_match (
    .clk(clk), .rst_n(rst_n), .d(req_in), .q(req_late)
  );

  if (OP == tsp_pkg::OP_INC) begin : g_inc
    assign logic_out = data_in + W'(1);
  end else begin : g_pass
    assign logic_out = data_in;
  end

  assign en = ~(done_q ^ done_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else if (en) begin
      done_q <= req_late;
      data_q <= logic_out;
    end
  end

  assign done     = done_q;
  assign data_out = data_q;

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != $past(done_q)) |-> ($past(done_q) == $past(done_next)));

  // R7
  hold_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q != done_next) |-> $stable(data_q));
endmodule

// File: rtl/tsp_pipe.sv
module tsp_pipe #(
  parameter int                 W          = 8,
  parameter int                 NUM_STAGES = 4,
  parameter int                 MATCH_DLY  = 1,
  parameter tsp_pkg::stage_op_e OP         = tsp_pkg::OP_INC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_req,
  input  logic [W-1:0] a_data,
  output logic         a_ack,
  input  logic         b_req,
  input  logic [W-1:0] b_data,
  output logic         b_ack,
  output logic         x_req,
  output logic [W-1:0] x_data,
  input  logic         x_ack,
  output logic         y_req,
  output logic [W-1:0] y_data,
  input  logic         y_ack
);
  localparam int LAST = NUM_STAGES - 1;

  logic         join_c;
  logic         fork_c;
  logic         rq [NUM_STAGES];
  logic         dn [NUM_STAGES+1];
  logic [W-1:0] dv [NUM_STAGES+1];

  tsp_celem #(.N_IN(2)) u_join (
    .clk(clk), .rst_n(rst_n), .ins({b_req, a_req}), .c_out(join_c)
  );

  tsp_celem #(.N_IN(2)) u_fork (
    .clk(clk), .rst_n(rst_n), .ins({y_ack, x_ack}), .c_out(fork_c)
  );

  assign dv[0]          = a_data + b_data;
  assign dn[NUM_STAGES] = fork_c;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign rq[g] = join_c;
    end else begin : g_body
      assign rq[g] = dn[g-1];
    end
    tsp_stage #(.W(W), .DLY(MATCH_DLY), .OP(OP)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (rq[g]),
      .data_in   (dv[g]),
      .done_next (dn[g+1]),
      .done      (dn[g]),
      .data_out  (dv[g+1])
    );
  end

  assign a_ack  = dn[0];
  assign b_ack  = dn[0];
  assign x_req  = dn[LAST];
  assign y_req  = dn[LAST];
  assign x_data = dv[NUM_STAGES];
  assign y_data = dv[NUM_STAGES];

  // R3
  join_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack != $past(a_ack)) |->
      (($past(a_req) != $past(a_ack)) && ($past(b_req) != $past(a_ack))));

  // R4
  fork_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req != $past(x_req)) |->
      (($past(x_ack) == $past(x_req)) && ($past(y_ack) == $past(x_req))));
endmodule

// File: tb/tsp_pipe_test.sv
module tsp_pipe_test;
  localparam int W   = 8;
  localparam int NS  = 4;
  localparam int DL  = 1;
  localparam int LAT = 1 + NS * (DL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req = 1'b0, b_req = 1'b0, x_ack = 1'b0, y_ack = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_ack, b_ack, x_req, y_req;
  logic [W-1:0] x_data, y_data;

  always #2 clk = ~clk;

  tsp_pipe #(.W(W), .NUM_STAGES(NS), .MATCH_DLY(DL)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_data(a_data), .a_ack(a_ack),
    .b_req(b_req), .b_data(b_data), .b_ack(b_ack),
    .x_req(x_req), .x_data(x_data), .x_ack(x_ack),
    .y_req(y_req), .y_data(y_data), .y_ack(y_ack)
  );

  int errors = 0, checks = 0;
  int rx_cnt = 0, acc_cnt = 0, sink_max = 2;
  bit sink_en = 1'b0, y_hold = 1'b0, busy = 1'b0;
  logic [W-1:0] exp_q [$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input int ga, input int gb);
    logic [W-1:0] e;
    repeat (ga) @(negedge clk);
    e = a + b + W'(NS);
    exp_q.push_back(e);
    a_data = a;
    a_req  = ~a_req;
    repeat (gb) @(negedge clk);
    b_data = b;
    b_req  = ~b_req;
    while (a_ack != a_req) @(negedge clk);
    acc_cnt++;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || busy) && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (sink_en && rst_n && x_req != x_ack) begin
        repeat ($urandom_range(0, sink_max)) @(negedge clk);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected item", int'(x_data), -1);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(x_data == e && y_data == e, "R2 item data/order", int'(x_data), int'(e));
        end
        rx_cnt++;
        x_ack = ~x_ack;
        while (y_hold) @(negedge clk);
        y_ack = x_ack;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat, acc0, rx0;
    logic [W-1:0] held;

    repeat (3) @(negedge clk);
    // R1
    chk(a_ack == 0 && b_ack == 0, "R1 acks in reset", int'(a_ack), 0);
    chk(x_req == 0 && y_req == 0, "R1 reqs in reset", int'(x_req), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(a_ack == 0 && x_req == 0 && y_req == 0, "R1 idle after reset", int'(x_req), 0);

    // R3: one producer alone does nothing
    sink_en = 1'b1;
    sink_max = 0;
    a_data = 8'd3;
    a_req  = 1'b1;
    repeat (20) @(negedge clk);
    chk(a_ack == 0 && b_ack == 0, "R3 ack after single toggle", int'(a_ack), 0);
    chk(x_req == 0, "R3 output after single toggle", int'(x_req), 0);
    exp_q.push_back(8'd3 + 8'd5 + W'(NS));
    b_data = 8'd5;
    b_req  = 1'b1;
    // R6 latency in an empty pipe
    lat = 0;
    while (x_req == 0 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == LAT, "R6 empty-pipe latency", lat, LAT);
    chk(a_ack == 1 && b_ack == 1, "R3 ack after both toggles", int'(b_ack), 1);
    drain();
    chk(rx_cnt == 1, "R2 first item count", rx_cnt, 1);

    // R5 / R7: stall both consumers
    sink_en = 1'b0;
    acc0 = acc_cnt;
    fork
      begin
        busy = 1'b1;
        for (int i = 0; i < 7; i++) send(W'(i * 7), W'(i + 1), 0, 0);
        busy = 1'b0;
      end
    join_none
    repeat (60) @(negedge clk);
    chk(acc_cnt - acc0 == NS, "R5 items accepted while stalled", acc_cnt - acc0, NS);
    held = x_data;
    chk(x_req != x_ack && held == exp_q[0], "R7 oldest item at output", int'(held), int'(exp_q[0]));
    repeat (30) @(negedge clk);
    chk(x_data == held, "R7 held data stable", int'(x_data), int'(held));
    chk(acc_cnt - acc0 == NS, "R5 acks still after full", acc_cnt - acc0, NS);
    sink_en = 1'b1;
    sink_max = 2;
    drain();
    chk(exp_q.size() == 0 && rx_cnt == 8, "R7 stall drained in order", rx_cnt, 8);

    // R4: consumer Y withholds its ack
    y_hold = 1'b1;
    rx0 = rx_cnt;
    fork
      begin
        busy = 1'b1;
        for (int i = 0; i < 3; i++) send(W'(40 + i), W'(2 * i), 1, 0);
        busy = 1'b0;
      end
    join_none
    repeat (60) @(negedge clk);
    chk(rx_cnt - rx0 == 1, "R4 single item while Y lags", rx_cnt - rx0, 1);
    chk(x_req == x_ack && y_ack != x_req, "R4 no new offer", int'(x_req), int'(x_ack));
    y_hold = 1'b0;
    drain();
    chk(rx_cnt - rx0 == 3, "R4 items after Y release", rx_cnt - rx0, 3);

    // R2: random traffic with a long stall in the middle
    sink_max = 3;
    fork
      begin
        repeat (400) @(negedge clk);
        sink_en = 1'b0;
        repeat (300) @(negedge clk);
        sink_en = 1'b1;
      end
    join_none
    busy = 1'b1;
    for (int i = 0; i < 150; i++)
      send(W'($urandom), W'($urandom), $urandom_range(0, 3), $urandom_range(0, 3));
    busy = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    chk(rx_cnt == 161, "R2 total delivered", rx_cnt, 161);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule